// File: doc/BRIEF.md
# Calibrated Bank Temperature Converter

This block turns raw 12-bit readings from a group ("bank") of up to four on-die temperature sensing points into signed millidegree Celsius values, and reports the hottest value of each bank. Samples arrive one at a time on a valid/ready stream. Each sample carries a sensor index and a flag that marks the last sample of its bank. The conversion uses device calibration: a gain error, one offset per sensor, a reference temperature and a signed slope trim. It also uses a fixed slope coefficient, which is a parameter: 165 by default, and 153 for the alternate configuration. When the calibration-valid input is low, fixed default calibration applies.

Each sample runs through a single shared restoring divider twice. The first division is a scaled constant over the trimmed slope, and the second divides that result by the gain term. The result is multiplied by the offset-corrected raw value, shifted right by three guard bits and subtracted from the scaled reference temperature. A value that is too hot to be believable is forced to zero, and the running bank maximum is updated. When the sample that ends a bank has been converted, the bank maximum appears for one cycle on the result port and the maximum is cleared for the next bank.

The controller is a four-state machine:
- ST_IDLE accepts a sample and starts division one, then moves to ST_DIV_Q1.
- ST_DIV_Q1 waits for the divider. When the divider finishes, it starts division two on the first quotient and moves to ST_DIV_Q2.
- ST_DIV_Q2 waits for the second quotient and then moves to ST_FINISH.
- ST_FINISH converts the sample, updates the maximum (emitting it if the bank ends) and returns to ST_IDLE.

Calibration inputs must be held stable while a conversion is in flight.

Top module: `thermo_bank_conv`

## Requirements
- R1: After reset `s_ready` is 1 and `m_valid` is 0.
- R2: Only bits [11:0] of `s_raw` take part in the conversion; bits [15:12] have no effect on the result.
- R3: A sample converts as Q = ((203450520·8) / (SLOPE_COEF + trim)) / (10000 + gain), with each division truncating. The temperature is ref·500 − ((Q · (raw − offset − 3350)) >>> 3). All arithmetic is signed 32-bit and the shift is arithmetic.
- R4: A converted value greater than 200000 is replaced by 0 before it enters the maximum.
- R5: At the sample with `s_bank_end`=1, `m_temp` gives the maximum of that bank's (clamped) values, starting from −2^31, and the maximum is then cleared. Banks made only of negative values report their true maximum.
- R6: While `cal_valid` is 0 the block uses gain 0x200 (512), offset 260 for every sensor, reference 40 and trim 0, and ignores all other calibration inputs.
- R7: The trim is the unsigned 6-bit `cal_trim`. It is negated only when `cal_trim_sign` and `cal_part_id` are both 1; otherwise it is added as positive.
- R8: `s_ready` drops the cycle after a sample is accepted and rises again only when that sample's conversion has finished.
- R9: `m_valid` pulses for exactly one cycle, only after a sample flagged `s_bank_end`; other samples never raise it.
- R10: The offset applied is the 9-bit field `cal_offsets[9*i+8 : 9*i]`, where i is the sample's `s_sensor` index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Block can take a sample |
| s_raw | input | 16 | Raw reading; low 12 bits used |
| s_sensor | input | 2 | Sensor index of the sample |
| s_bank_end | input | 1 | Sample is the last of its bank |
| cal_valid | input | 1 | Calibration inputs are valid |
| cal_gain_err | input | 10 | Gain error |
| cal_offsets | input | 36 | Four 9-bit sensor offsets, sensor i at bits 9i+8..9i |
| cal_ref_temp | input | 6 | Reference temperature in degrees |
| cal_trim | input | 6 | Slope trim magnitude |
| cal_trim_sign | input | 1 | Trim sign flag |
| cal_part_id | input | 1 | Part identity bit qualifying the sign |
| m_valid | output | 1 | Bank maximum valid (one cycle) |
| m_temp | output | 32 | Bank maximum, signed millidegrees |

## Verification
Single-sample banks under the default calibration tell the arithmetic itself apart: the truncation of both divisions, the rounding toward minus infinity of the guard shift, and the forced-to-zero hot region. Raw values with junk in the top nibble show whether masking happens. Each sensor index paired with a distinct offset shows whether the offset field is chosen correctly. Positive, negated and sign-without-id trims separate the three cases of the sign rule. Multi-sample banks that are all negative, all clamped or mixed show whether the maximum starts from the most negative value and is cleared between banks. Seeded random banks with random calibration then sweep the full range against the bench model.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIV_Q1,
        ST_DIV_Q2,
        ST_FINISH
    } conv_state_e;

    localparam int unsigned SCALE_BASE = 203450520;
    localparam int unsigned GUARD_BITS = 3;
    localparam logic [31:0] SCALE_NUM  = 32'(SCALE_BASE) << GUARD_BITS;
    localparam int RAW_BIAS    = 3350;
    localparam int HOT_LIMIT   = 200000;
    localparam int GAIN_BASE   = 10000;
    localparam int REF_SCALE   = 500;
    localparam int DEF_GAIN    = 512;
    localparam int DEF_OFFSET  = 260;
    localparam int DEF_REF     = 40;
    localparam logic signed [31:0] TEMP_FLOOR = 32'sh8000_0000;
endpackage

// File: rtl/thermo_divider.sv
module thermo_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_q, quo_q, dvs_q, dnd_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W:0]       rem_sh, trial;
    logic [W-1:0]     rem_d, quo_d;

    // one restoring step: shift in the next dividend bit, try a subtract
    always_comb begin
        rem_sh = {rem_q, quo_q[W-1]};
        trial  = rem_sh - {1'b0, dvs_q};
        if (trial[W]) begin
            rem_d = rem_sh[W-1:0];
            quo_d = {quo_q[W-2:0], 1'b0};
        end else begin
            rem_d = trial[W-1:0];
            quo_d = {quo_q[W-2:0], 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            dnd_q <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                rem_q <= '0;
                quo_q <= dividend;
                dnd_q <= dividend;
                dvs_q <= divisor;
                cnt_q <= CNT_W'(W);
                busy  <= 1'b1;
            end else if (busy) begin
                rem_q <= rem_d;
                quo_q <= quo_d;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;

    // quotient must be the truncated quotient of the latched operands
    assert_div_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (((2*W)'(quotient) * (2*W)'(dvs_q)) <= (2*W)'(dnd_q)) &&
                 (((2*W)'(dnd_q) - (2*W)'(quotient) * (2*W)'(dvs_q)) < (2*W)'(dvs_q)));

    assert_start_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/thermo_cal_sel.sv
module thermo_cal_sel
    import thermo_pkg::*;
#(
    parameter int N_SENS     = 4,
    parameter int GAIN_W     = 10,
    parameter int OFF_W      = 9,
    parameter int REF_W      = 6,
    parameter int TRIM_W     = 6,
    parameter int SLOPE_COEF = 165,
    localparam int SEL_W     = (N_SENS > 1) ? $clog2(N_SENS) : 1
) (
    input  logic                    cal_valid,
    input  logic [GAIN_W-1:0]       cal_gain_err,
    input  logic [N_SENS*OFF_W-1:0] cal_offsets,
    input  logic [REF_W-1:0]        cal_ref_temp,
    input  logic [TRIM_W-1:0]       cal_trim,
    input  logic                    cal_trim_sign,
    input  logic                    cal_part_id,
    input  logic [SEL_W-1:0]        sel,
    output logic [31:0]             slope_div,
    output logic [31:0]             gain_div,
    output logic signed [31:0]      offset,
    output logic signed [31:0]      ref_mt
);
    logic [OFF_W-1:0] off_arr [N_SENS];

    for (genvar i = 0; i < N_SENS; i++) begin : g_off
        assign off_arr[i] = cal_offsets[i*OFF_W +: OFF_W];
    end

    logic signed [31:0] trim_s;

    always_comb begin
        if (cal_valid) begin
            trim_s = 32'($unsigned(cal_trim));
            if (cal_trim_sign && cal_part_id) trim_s = -trim_s;
            gain_div = 32'(GAIN_BASE) + 32'($unsigned(cal_gain_err));
            offset   = (int'(sel) < N_SENS) ? 32'($unsigned(off_arr[sel])) : 32'sd0;
            ref_mt   = 32'($unsigned(cal_ref_temp)) * 32'(REF_SCALE);
        end else begin
            trim_s   = 32'sd0;
            gain_div = 32'(GAIN_BASE + DEF_GAIN);
            offset   = 32'(DEF_OFFSET);
            ref_mt   = 32'(DEF_REF * REF_SCALE);
        end
        slope_div = 32'(SLOPE_COEF) + 32'(trim_s);
    end

    // slope divisor stays positive for any legal trim
    always_comb begin
        assert_slope_pos_R7: assert ($signed(slope_div) > 0);
    end
endmodule

// File: rtl/thermo_max_acc.sv
module thermo_max_acc
    import thermo_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd,
    input  logic               bank_end,
    input  logic signed [31:0] sample,
    output logic               out_valid,
    output logic signed [31:0] out_temp
);
    logic signed [31:0] acc_q, kept, cand;

    always_comb begin
        kept = (sample > HOT_LIMIT) ? 32'sd0 : sample;
        cand = (kept > acc_q) ? kept : acc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= TEMP_FLOOR;
            out_valid <= 1'b0;
            out_temp  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (upd) begin
                if (bank_end) begin
                    out_valid <= 1'b1;
                    out_temp  <= cand;
                    acc_q     <= TEMP_FLOOR;
                end else begin
                    acc_q <= cand;
                end
            end
        end
    end

    assert_emit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd && bank_end |=> out_valid);
    assert_clamped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_temp <= HOT_LIMIT);
    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd && bank_end) |=> !out_valid);
endmodule

// File: rtl/thermo_bank_conv.sv
module thermo_bank_conv
    import thermo_pkg::*;
#(
    parameter int SLOPE_COEF = 165,
    parameter int N_SENS     = 4,
    parameter int RAW_W      = 16,
    parameter int ADC_BITS   = 12,
    parameter int GAIN_W     = 10,
    parameter int OFF_W      = 9,
    parameter int REF_W      = 6,
    parameter int TRIM_W     = 6,
    localparam int SEL_W     = (N_SENS > 1) ? $clog2(N_SENS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s_valid,
    output logic                    s_ready,
    input  logic [RAW_W-1:0]        s_raw,
    input  logic [SEL_W-1:0]        s_sensor,
    input  logic                    s_bank_end,
    input  logic                    cal_valid,
    input  logic [GAIN_W-1:0]       cal_gain_err,
    input  logic [N_SENS*OFF_W-1:0] cal_offsets,
    input  logic [REF_W-1:0]        cal_ref_temp,
    input  logic [TRIM_W-1:0]       cal_trim,
    input  logic                    cal_trim_sign,
    input  logic                    cal_part_id,
    output logic                    m_valid,
    output logic signed [31:0]      m_temp
);
    conv_state_e state_q, state_d;

    logic [ADC_BITS-1:0] raw_q;
    logic [SEL_W-1:0]    sel_q;
    logic                end_q;
    logic                unused_raw_hi;

    logic        div_start, div_busy, div_done;
    logic [31:0] div_dividend, div_divisor, div_quo;
    logic [31:0] slope_div, gain_div;
    logic signed [31:0] offset, ref_mt;
    logic signed [31:0] raw_s, diff, quo_s, prod, temp;
    logic        acc_upd;

    assign unused_raw_hi = ^s_raw[RAW_W-1:ADC_BITS];

    thermo_cal_sel #(
        .N_SENS(N_SENS), .GAIN_W(GAIN_W), .OFF_W(OFF_W),
        .REF_W(REF_W), .TRIM_W(TRIM_W), .SLOPE_COEF(SLOPE_COEF)
    ) u_cal (
        .cal_valid(cal_valid), .cal_gain_err(cal_gain_err),
        .cal_offsets(cal_offsets), .cal_ref_temp(cal_ref_temp),
        .cal_trim(cal_trim), .cal_trim_sign(cal_trim_sign),
        .cal_part_id(cal_part_id), .sel(sel_q),
        .slope_div(slope_div), .gain_div(gain_div),
        .offset(offset), .ref_mt(ref_mt)
    );

    thermo_divider #(.W(32)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .dividend(div_dividend), .divisor(div_divisor),
        .busy(div_busy), .done(div_done), .quotient(div_quo)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and control outputs
    always_comb begin
        state_d      = state_q;
        s_ready      = 1'b0;
        div_start    = 1'b0;
        div_dividend = SCALE_NUM;
        div_divisor  = slope_div;
        acc_upd      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                s_ready = 1'b1;
                if (s_valid) begin
                    div_start = 1'b1;
                    state_d   = ST_DIV_Q1;
                end
            end
            ST_DIV_Q1: begin
                if (div_done) begin
                    div_start    = 1'b1;
                    div_dividend = div_quo;
                    div_divisor  = gain_div;
                    state_d      = ST_DIV_Q2;
                end
            end
            ST_DIV_Q2: begin
                if (div_done) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                acc_upd = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
            sel_q <= '0;
            end_q <= 1'b0;
        end else if (s_valid && s_ready) begin
            raw_q <= s_raw[ADC_BITS-1:0];
            sel_q <= s_sensor;
            end_q <= s_bank_end;
        end
    end

    // conversion of the held sample from the second quotient
    always_comb begin
        raw_s = 32'(raw_q);
        diff  = raw_s - offset - 32'(RAW_BIAS);
        quo_s = div_quo;
        prod  = quo_s * diff;
        temp  = ref_mt - (prod >>> GUARD_BITS);
    end

    thermo_max_acc u_max (
        .clk(clk), .rst_n(rst_n), .upd(acc_upd), .bank_end(end_q),
        .sample(temp), .out_valid(m_valid), .out_temp(m_temp)
    );

    assert_accept_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid && s_ready |=> !s_ready);
    assert_result_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> s_ready);
    assert_wait_div_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIV_Q2) && !div_done |-> div_busy);
endmodule

// File: tb/tb_thermo_bank_conv.sv
module tb_thermo_bank_conv;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [15:0] s_raw = '0;
    logic [1:0]  s_sensor = '0;
    logic        s_bank_end = 1'b0;
    logic        cal_valid = 1'b0;
    logic [9:0]  cal_gain_err = '0;
    logic [35:0] cal_offsets = '0;
    logic [5:0]  cal_ref_temp = '0;
    logic [5:0]  cal_trim = '0;
    logic        cal_trim_sign = 1'b0;
    logic        cal_part_id = 1'b0;
    logic        m_valid;
    logic signed [31:0] m_temp;

    int checks = 0;
    int errors = 0;
    int br [4];
    int bs [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    thermo_bank_conv dut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_raw(s_raw), .s_sensor(s_sensor), .s_bank_end(s_bank_end),
        .cal_valid(cal_valid), .cal_gain_err(cal_gain_err),
        .cal_offsets(cal_offsets), .cal_ref_temp(cal_ref_temp),
        .cal_trim(cal_trim), .cal_trim_sign(cal_trim_sign),
        .cal_part_id(cal_part_id), .m_valid(m_valid), .m_temp(m_temp)
    );

    function automatic int model(int raw, int sel);
        int ge, off, rf, tr, t;
        if (cal_valid) begin
            ge = int'(cal_gain_err);
            off = int'(cal_offsets[sel*9 +: 9]);
            rf = int'(cal_ref_temp);
            tr = (cal_trim_sign && cal_part_id) ? -int'(cal_trim) : int'(cal_trim);
        end else begin
            ge = 512; off = 260; rf = 40; tr = 0;
        end
        t = 1627604160;
        t = t / (165 + tr);
        t = t / (10000 + ge);
        t = t * ((raw & 4095) - off - 3350);
        t = t >>> 3;
        return rf * 500 - t;
    endfunction

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic send(int raw, int sel, bit last);
        @(negedge clk);
        s_valid = 1'b1; s_raw = 16'(raw); s_sensor = 2'(sel); s_bank_end = last;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b0;
        check("R8 ready low after accept", int'(s_ready), 0);
        if (!last) begin
            while (!s_ready) begin
                if (m_valid) check("R9 no result mid-bank", 1, 0);
                @(negedge clk);
            end
            check("R9 no result after non-final sample", int'(m_valid), 0);
        end
    endtask

    task automatic run_bank(int n, string req);
        int exp, t, wait_cnt;
        exp = 32'sh8000_0000;
        for (int i = 0; i < n; i++) begin
            t = model(br[i], bs[i]);
            if (t > 200000) t = 0;
            if (t > exp) exp = t;
        end
        for (int i = 0; i < n; i++) send(br[i], bs[i], i == n - 1);
        wait_cnt = 0;
        while (!m_valid && wait_cnt < 500) begin
            @(negedge clk);
            wait_cnt++;
        end
        if (!m_valid) begin
            check({req, " result timeout"}, 0, 1);
        end else begin
            check(req, m_temp, exp);
            @(negedge clk);
            check("R9 single-cycle result", int'(m_valid), 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        check("R1 ready in reset", int'(s_ready), 1);
        check("R1 no result in reset", int'(m_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", int'(s_ready), 1);
        check("R1 no result after reset", int'(m_valid), 0);

        // R6: defaults with garbage calibration ports
        cal_valid = 1'b0; cal_gain_err = 10'h3FF; cal_offsets = '1;
        cal_ref_temp = 6'd63; cal_trim = 6'd63; cal_trim_sign = 1; cal_part_id = 1;
        br[0] = 3000; bs[0] = 0; run_bank(1, "R6 default calibration");
        br[0] = 3500; bs[0] = 3; run_bank(1, "R6 R3 default conversion");

        // R2: upper raw bits ignored
        br[0] = 16'hF000 | 3000; bs[0] = 1; run_bank(1, "R2 raw upper bits masked");
        br[0] = 16'h5000 | 3800; bs[0] = 2; run_bank(1, "R2 raw upper bits masked b");

        // R4: too-hot readings become zero
        br[0] = 2000; bs[0] = 0; run_bank(1, "R4 hot clamp single");
        br[0] = 100; br[1] = 1500; bs[0] = 1; bs[1] = 2; run_bank(2, "R4 all clamped bank");

        // R5: maximum starts from most negative, cleared between banks
        br[0] = 4095; br[1] = 4000; br[2] = 4090; bs[0] = 0; bs[1] = 1; bs[2] = 2;
        run_bank(3, "R5 all negative bank");
        br[0] = 4095; br[1] = 2000; br[2] = 3300; br[3] = 3900;
        bs[0] = 0; bs[1] = 1; bs[2] = 2; bs[3] = 3;
        run_bank(4, "R5 mixed bank max");
        br[0] = 4095; bs[0] = 0; run_bank(1, "R5 max cleared after bank");

        // R7: trim sign rule
        cal_valid = 1'b1; cal_gain_err = 10'd300; cal_offsets = {4{9'd250}};
        cal_ref_temp = 6'd35; cal_trim = 6'd40;
        cal_trim_sign = 1; cal_part_id = 0;
        br[0] = 3200; bs[0] = 0; run_bank(1, "R7 sign without id adds");
        cal_trim_sign = 1; cal_part_id = 1;
        run_bank(1, "R7 sign and id negates");
        cal_trim_sign = 0; cal_part_id = 1;
        run_bank(1, "R7 id without sign adds");

        // R10: offset selection per sensor
        cal_trim = 6'd5; cal_trim_sign = 0;
        cal_offsets = {9'd511, 9'd300, 9'd100, 9'd0};
        for (int i = 0; i < 4; i++) begin
            br[0] = 3400; bs[0] = i; run_bank(1, "R10 offset field by index");
        end

        // R3: seeded random banks
        for (int k = 0; k < 40; k++) begin
            if ($urandom_range(0, 3) == 0) begin
                cal_valid = ($urandom_range(0, 3) != 0);
                cal_gain_err = 10'($urandom());
                cal_offsets = {4'($urandom()), $urandom()};
                cal_ref_temp = 6'($urandom());
                cal_trim = 6'($urandom());
                cal_trim_sign = 1'($urandom());
                cal_part_id = 1'($urandom());
            end
            for (int i = 0; i < 4; i++) begin
                br[i] = int'($urandom_range(0, 65535));
                bs[i] = int'($urandom_range(0, 3));
            end
            run_bank(int'($urandom_range(1, 4)), "R3 random bank");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule